// File: doc/BRIEF.md
# Serial Audio Frame-Sync Pin Multiplexer

This block owns the two frame-sync pads of a multichannel serial audio port: the receive-side pad and the transmit-side pad. Mode inputs decide what each pad does. The receive-side pad can carry a frame sync, act as a serial flag in either direction, or drive an external buffer enable. The transmit-side pad carries a frame sync in either direction. Either pad can also be handed over to general-purpose I/O. In that case it can be an input, an output, or disconnected.

Pad inputs pass through a synchronizer of at least two stages before any logic uses them. The block gives the receive and transmit cores the frame syncs they should use. It keeps the flag bit shown on the pad and captures the incoming flag status. Flag transfers happen at a frame-start strobe in normal mode, or at a slot-start strobe in network mode. The surrounding port supplies the clock generation, the shift registers and the control registers.

Top module: `fsmux_top`

## Requirements
- R1: While `rst_n` is low, both pad output enables are 0, `if1_stat` is 0 and the held output-flag value is 0. The pads are first driven after the first rising clock edge once reset has been released.
- R2: With `syn_mode`=0 and the receive pad not in GPIO, `rx_dir`=1 drives `rx_fs_int` onto the receive pad with the enable at 1, and `rx_fs_core` follows `rx_fs_int`. With `rx_dir`=0 the receive-pad enable is 0, and `rx_fs_core` shows the pad level two clock edges after the pad changes.
- R3: With the transmit pad not in GPIO, `tx_dir`=1 drives `tx_fs_int` onto the transmit pad with the enable at 1, and `tx_fs_core` follows it. With `tx_dir`=0 the enable is 0, and `tx_fs_core` shows the pad level two edges after the pad changes.
- R4: With `syn_mode`=1, `rx_fs_core` always equals `tx_fs_core`, so the receivers use the transmit-pad frame sync.
- R5: With `syn_mode`=1, `bufen_sel`=0 and `rx_dir`=1, the receive pad is driven with the held output-flag value. That value takes `of1_bit` at an edge where the active flag strobe is high, and does not change at any other edge.
- R6: With `syn_mode`=1, `bufen_sel`=0 and `rx_dir`=0, the receive-pad enable is 0. `if1_stat` takes the synchronized pad level at an edge where the active flag strobe is high, and holds at all other edges.
- R7: The active flag strobe is `slot_stb` when `net_mode`=1 and `frame_stb` when `net_mode`=0. The other strobe has no effect on either flag. If `of1_bit` changes in the same cycle as the strobe, the new value is the one taken.
- R8: With `syn_mode`=1, `bufen_sel`=1 and `rx_dir`=1, the receive pad is enabled and drives `tx_slot_act`.
- R9: A pad in GPIO (`*_gpio_en`=1) uses a 2-bit mode. 2'b10 is output: the pad is enabled and driven with the GPIO data bit. 2'b01 is input: the enable is 0 and `*_gpio_in` shows the pad level two edges later.
- R10: A pad in GPIO with mode 2'b00 or 2'b11 is disconnected. Its enable is 0, its `*_gpio_in` is 0, `if1_stat` does not change, and the core frame sync derived from that pad is 0.
- R11: With `syn_mode`=1, `bufen_sel`=1 and `rx_dir`=0, the receive pad is not driven, and its level changes neither `if1_stat` nor any core frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| syn_mode | input | 1 | 1 = transmit and receive share one frame sync |
| bufen_sel | input | 1 | In shared mode, selects the buffer-enable role for the receive pad |
| rx_dir | input | 1 | Receive-pad direction, 1 = output |
| tx_dir | input | 1 | Transmit-pad direction, 1 = output |
| net_mode | input | 1 | 1 = flags move on slot strobes, 0 = on frame strobes |
| rx_gpio_en | input | 1 | Receive pad handed to GPIO |
| rx_gpio_mode | input | 2 | Receive-pad GPIO mode (01 in, 10 out, else disconnected) |
| rx_gpio_dout | input | 1 | Receive-pad GPIO output data |
| tx_gpio_en | input | 1 | Transmit pad handed to GPIO |
| tx_gpio_mode | input | 2 | Transmit-pad GPIO mode (01 in, 10 out, else disconnected) |
| tx_gpio_dout | input | 1 | Transmit-pad GPIO output data |
| rx_fs_int | input | 1 | Internally generated receive frame sync |
| tx_fs_int | input | 1 | Internally generated transmit frame sync |
| frame_stb | input | 1 | One-cycle frame-start strobe |
| slot_stb | input | 1 | One-cycle slot-start strobe |
| tx_slot_act | input | 1 | High during an active transmit slot |
| of1_bit | input | 1 | Output flag control bit |
| rx_pad_in | input | 1 | Receive pad input level |
| tx_pad_in | input | 1 | Transmit pad input level |
| rx_pad_out | output | 1 | Receive pad output value |
| rx_pad_oe | output | 1 | Receive pad output enable |
| tx_pad_out | output | 1 | Transmit pad output value |
| tx_pad_oe | output | 1 | Transmit pad output enable |
| if1_stat | output | 1 | Captured input flag |
| rx_fs_core | output | 1 | Frame sync for the receivers |
| tx_fs_core | output | 1 | Frame sync for the transmitters |
| rx_gpio_in | output | 1 | Receive-pad GPIO input data |
| tx_gpio_in | output | 1 | Transmit-pad GPIO input data |

## Verification
Two events can fall in the same cycle: the flag strobe, and a change of the value it transfers. The bench raises `of1_bit` in the same cycle as `slot_stb` in network mode, and then drives both strobes together. It then looks at the pad one edge later and expects the new bit. It also checks that the strobe for the other mode did nothing, both before and after this test.

// File: rtl/fsmux_pkg.sv
package fsmux_pkg;

   typedef enum logic [1:0] {
      GM_OFF_A = 2'b00,
      GM_IN    = 2'b01,
      GM_OUT   = 2'b10,
      GM_OFF_B = 2'b11
   } gpio_mode_e;

   typedef enum logic [2:0] {
      RXR_FS_IN,
      RXR_FS_OUT,
      RXR_FLAG_IN,
      RXR_FLAG_OUT,
      RXR_BUFEN,
      RXR_IDLE
   } rx_role_e;

   function automatic rx_role_e rx_role_decode(input logic syn, input logic bsel,
                                               input logic dir);
      rx_role_e r;
      if (!syn)       r = dir ? RXR_FS_OUT : RXR_FS_IN;
      else if (!bsel) r = dir ? RXR_FLAG_OUT : RXR_FLAG_IN;
      else            r = dir ? RXR_BUFEN : RXR_IDLE;
      return r;
   endfunction

endpackage

// File: rtl/fsmux_sync.sv
module fsmux_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("fsmux_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fsmux_pin.sv
module fsmux_pin
   import fsmux_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       gpio_en,
   input  logic [1:0] gpio_mode,
   input  logic       gpio_dout,
   input  logic       func_oe,
   input  logic       func_out,
   input  logic       pad_in,
   output logic       pad_out,
   output logic       pad_oe,
   output logic       func_in,
   output logic       gpio_in
);
   logic       pad_sync;
   gpio_mode_e gm;

   assign gm = gpio_mode_e'(gpio_mode);

   fsmux_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (pad_sync)
   );

   always_comb begin
      pad_out = 1'b0;
      pad_oe  = 1'b0;
      gpio_in = 1'b0;
      func_in = 1'b0;
      if (gpio_en) begin
         unique case (gm)
            GM_OUT: begin
               pad_out = gpio_dout;
               pad_oe  = run;
            end
            GM_IN:   gpio_in = pad_sync;
            default: ;
         endcase
      end else begin
         pad_out = func_out;
         pad_oe  = run & func_oe;
         func_in = pad_sync;
      end
   end
endmodule

// File: rtl/fsmux_flag.sv
module fsmux_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic net_mode,
   input  logic frame_stb,
   input  logic slot_stb,
   input  logic of1_bit,
   input  logic cap_en,
   input  logic flag_in,
   output logic of1_hold,
   output logic if1_stat
);
   logic stb;

   assign stb = net_mode ? slot_stb : frame_stb;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   of1_hold <= 1'b0;
      else if (stb) of1_hold <= of1_bit;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)             if1_stat <= 1'b0;
      else if (stb && cap_en) if1_stat <= flag_in;
endmodule

// File: rtl/fsmux_top.sv
module fsmux_top
   import fsmux_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       syn_mode,
   input  logic       bufen_sel,
   input  logic       rx_dir,
   input  logic       tx_dir,
   input  logic       net_mode,
   input  logic       rx_gpio_en,
   input  logic [1:0] rx_gpio_mode,
   input  logic       rx_gpio_dout,
   input  logic       tx_gpio_en,
   input  logic [1:0] tx_gpio_mode,
   input  logic       tx_gpio_dout,
   input  logic       rx_fs_int,
   input  logic       tx_fs_int,
   input  logic       frame_stb,
   input  logic       slot_stb,
   input  logic       tx_slot_act,
   input  logic       of1_bit,
   input  logic       rx_pad_in,
   input  logic       tx_pad_in,
   output logic       rx_pad_out,
   output logic       rx_pad_oe,
   output logic       tx_pad_out,
   output logic       tx_pad_oe,
   output logic       if1_stat,
   output logic       rx_fs_core,
   output logic       tx_fs_core,
   output logic       rx_gpio_in,
   output logic       tx_gpio_in
);
   localparam int NPINS  = 2;
   localparam int RX_IDX = 0;
   localparam int TX_IDX = 1;

   logic             run_q;
   rx_role_e         rx_role;
   logic             of1_hold;
   logic             rx_cap_en;

   logic [NPINS-1:0] p_en, p_dout, p_foe, p_fout, p_pin;
   logic [NPINS-1:0] p_pout, p_poe, p_fin, p_gin;
   logic [1:0]       p_mode [NPINS];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;

   assign rx_role = rx_role_decode(syn_mode, bufen_sel, rx_dir);

   always_comb begin
      p_foe[RX_IDX]  = 1'b0;
      p_fout[RX_IDX] = 1'b0;
      unique case (rx_role)
         RXR_FS_OUT:   begin p_foe[RX_IDX] = 1'b1; p_fout[RX_IDX] = rx_fs_int;   end
         RXR_FLAG_OUT: begin p_foe[RX_IDX] = 1'b1; p_fout[RX_IDX] = of1_hold;    end
         RXR_BUFEN:    begin p_foe[RX_IDX] = 1'b1; p_fout[RX_IDX] = tx_slot_act; end
         default: ;
      endcase
      p_foe[TX_IDX]  = tx_dir;
      p_fout[TX_IDX] = tx_fs_int;
   end

   assign p_en[RX_IDX]   = rx_gpio_en;
   assign p_en[TX_IDX]   = tx_gpio_en;
   assign p_mode[RX_IDX] = rx_gpio_mode;
   assign p_mode[TX_IDX] = tx_gpio_mode;
   assign p_dout[RX_IDX] = rx_gpio_dout;
   assign p_dout[TX_IDX] = tx_gpio_dout;
   assign p_pin[RX_IDX]  = rx_pad_in;
   assign p_pin[TX_IDX]  = tx_pad_in;

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         fsmux_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q),
            .gpio_en  (p_en[i]),
            .gpio_mode(p_mode[i]),
            .gpio_dout(p_dout[i]),
            .func_oe  (p_foe[i]),
            .func_out (p_fout[i]),
            .pad_in   (p_pin[i]),
            .pad_out  (p_pout[i]),
            .pad_oe   (p_poe[i]),
            .func_in  (p_fin[i]),
            .gpio_in  (p_gin[i])
         );
      end
   endgenerate

   assign rx_cap_en = (rx_role == RXR_FLAG_IN) && !rx_gpio_en;

   fsmux_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .net_mode (net_mode),
      .frame_stb(frame_stb),
      .slot_stb (slot_stb),
      .of1_bit  (of1_bit),
      .cap_en   (rx_cap_en),
      .flag_in  (p_fin[RX_IDX]),
      .of1_hold (of1_hold),
      .if1_stat (if1_stat)
   );

   always_comb begin
      if (tx_gpio_en)  tx_fs_core = 1'b0;
      else if (tx_dir) tx_fs_core = tx_fs_int;
      else             tx_fs_core = p_fin[TX_IDX];
      if (syn_mode)        rx_fs_core = tx_fs_core;
      else if (rx_gpio_en) rx_fs_core = 1'b0;
      else if (rx_dir)     rx_fs_core = rx_fs_int;
      else                 rx_fs_core = p_fin[RX_IDX];
   end

   assign rx_pad_out = p_pout[RX_IDX];
   assign rx_pad_oe  = p_poe[RX_IDX];
   assign tx_pad_out = p_pout[TX_IDX];
   assign tx_pad_oe  = p_poe[TX_IDX];
   assign rx_gpio_in = p_gin[RX_IDX];
   assign tx_gpio_in = p_gin[TX_IDX];
endmodule

// File: rtl/fsmux_chk.sv
module fsmux_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       syn_mode,
   input logic       bufen_sel,
   input logic       rx_dir,
   input logic       tx_dir,
   input logic       net_mode,
   input logic       rx_gpio_en,
   input logic [1:0] rx_gpio_mode,
   input logic       tx_gpio_en,
   input logic [1:0] tx_gpio_mode,
   input logic       frame_stb,
   input logic       slot_stb,
   input logic       tx_slot_act,
   input logic       rx_pad_out,
   input logic       rx_pad_oe,
   input logic       tx_pad_oe,
   input logic       if1_stat,
   input logic       rx_fs_core,
   input logic       tx_fs_core,
   input logic       rx_gpio_in
);
   logic act_stb, of1_role, if1_role, be_role, rx_disc, tx_disc;

   assign act_stb  = net_mode ? slot_stb : frame_stb;
   assign of1_role = !rx_gpio_en && syn_mode && !bufen_sel && rx_dir;
   assign if1_role = !rx_gpio_en && syn_mode && !bufen_sel && !rx_dir;
   assign be_role  = !rx_gpio_en && syn_mode && bufen_sel && rx_dir;
   assign rx_disc  = rx_gpio_en && (rx_gpio_mode == 2'b00 || rx_gpio_mode == 2'b11);
   assign tx_disc  = tx_gpio_en && (tx_gpio_mode == 2'b00 || tx_gpio_mode == 2'b11);

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!rx_pad_oe && !tx_pad_oe && !if1_stat));                          // R1
   AST_TX_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !tx_gpio_en) |-> (tx_pad_oe == tx_dir));                     // R3
   AST_SHARED_FS: assert property (@(posedge clk) disable iff (!rst_n)
      syn_mode |-> (rx_fs_core == tx_fs_core));                                     // R4
   AST_OF1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (of1_role && !act_stb) |=> (!of1_role || $stable(rx_pad_out)));               // R5
   AST_IF1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(if1_role && act_stb) |=> $stable(if1_stat));                                // R6
   AST_BUFEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && be_role) |-> (rx_pad_oe && rx_pad_out == tx_slot_act));      // R8
   AST_DISC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_disc |-> (!rx_pad_oe && !rx_gpio_in));                                     // R10
   AST_DISC_NOFS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_disc |-> (!tx_pad_oe && !tx_fs_core));                                     // R10
endmodule

bind fsmux_top fsmux_chk u_chk (.*);

// File: tb/fsmux_top_bench.sv
`timescale 1ns/1ps
module fsmux_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       syn_mode = 0, bufen_sel = 0, rx_dir = 0, tx_dir = 0, net_mode = 0;
   logic       rx_gpio_en = 0, rx_gpio_dout = 0, tx_gpio_en = 0, tx_gpio_dout = 0;
   logic [1:0] rx_gpio_mode = 2'b00, tx_gpio_mode = 2'b00;
   logic       rx_fs_int = 0, tx_fs_int = 0, frame_stb = 0, slot_stb = 0;
   logic       tx_slot_act = 0, of1_bit = 0, rx_pad_in = 0, tx_pad_in = 0;
   logic       rx_pad_out, rx_pad_oe, tx_pad_out, tx_pad_oe, if1_stat;
   logic       rx_fs_core, tx_fs_core, rx_gpio_in, tx_gpio_in;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   fsmux_top u_fsmux_top (.*);

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic pulse_frame();
      frame_stb = 1; step(1); frame_stb = 0;
   endtask

   task automatic pulse_slot();
      slot_stb = 1; step(1); slot_stb = 0;
   endtask

   task automatic t_reset();
      rx_dir = 1; tx_dir = 1; rx_fs_int = 1; tx_fs_int = 1;
      #15;
      chk("R1 rx oe in reset", rx_pad_oe, 1'b0);
      chk("R1 tx oe in reset", tx_pad_oe, 1'b0);
      chk("R1 if1 in reset", if1_stat, 1'b0);
      rst_n = 1; #1;
      chk("R1 rx oe before first edge", rx_pad_oe, 1'b0);
      step(1);
      chk("R1 rx oe after first edge", rx_pad_oe, 1'b1);
      chk("R1 tx oe after first edge", tx_pad_oe, 1'b1);
      rx_fs_int = 0; tx_fs_int = 0;
   endtask

   task automatic t_async_rx();
      syn_mode = 0; rx_dir = 1; rx_fs_int = 1; #1;
      chk("R2 rx out drives fs", rx_pad_out, 1'b1);
      chk("R2 rx out core fs", rx_fs_core, 1'b1);
      rx_fs_int = 0; rx_dir = 0; rx_pad_in = 1; #1;
      chk("R2 rx in oe", rx_pad_oe, 1'b0);
      step(1);
      chk("R2 rx in after one edge", rx_fs_core, 1'b0);
      step(1);
      chk("R2 rx in after two edges", rx_fs_core, 1'b1);
      rx_pad_in = 0; step(2);
   endtask

   task automatic t_tx();
      tx_dir = 1; tx_fs_int = 1; #1;
      chk("R3 tx out value", tx_pad_out, 1'b1);
      chk("R3 tx out core", tx_fs_core, 1'b1);
      tx_fs_int = 0; tx_dir = 0; tx_pad_in = 1; #1;
      chk("R3 tx in oe", tx_pad_oe, 1'b0);
      step(1);
      chk("R3 tx in after one edge", tx_fs_core, 1'b0);
      step(1);
      chk("R3 tx in after two edges", tx_fs_core, 1'b1);
      syn_mode = 1; rx_dir = 0; #1;
      chk("R4 rx core shares tx fs", rx_fs_core, 1'b1);
      tx_pad_in = 0; step(2);
      chk("R4 rx core follows tx low", rx_fs_core, 1'b0);
   endtask

   task automatic t_of1();
      syn_mode = 1; bufen_sel = 0; rx_dir = 1; net_mode = 0;
      of1_bit = 1; step(2);
      chk("R5 of1 no strobe", rx_pad_out, 1'b0);
      chk("R5 of1 oe", rx_pad_oe, 1'b1);
      pulse_slot();
      chk("R7 slot ignored normal mode", rx_pad_out, 1'b0);
      pulse_frame();
      chk("R5 of1 at frame strobe", rx_pad_out, 1'b1);
      net_mode = 1; of1_bit = 0;
      pulse_frame();
      chk("R7 frame ignored network mode", rx_pad_out, 1'b1);
      pulse_slot();
      chk("R5 of1 at slot strobe", rx_pad_out, 1'b0);
      of1_bit = 1; slot_stb = 1; step(1); slot_stb = 0;
      chk("R7 bit change same cycle as strobe", rx_pad_out, 1'b1);
      of1_bit = 0; slot_stb = 1; frame_stb = 1; step(1);
      slot_stb = 0; frame_stb = 0;
      chk("R7 both strobes together", rx_pad_out, 1'b0);
      of1_bit = 1; step(3);
      chk("R5 of1 holds between strobes", rx_pad_out, 1'b0);
   endtask

   task automatic t_if1();
      syn_mode = 1; bufen_sel = 0; rx_dir = 0; net_mode = 0;
      rx_pad_in = 1; step(2);
      chk("R6 if1 oe", rx_pad_oe, 1'b0);
      chk("R6 if1 before strobe", if1_stat, 1'b0);
      pulse_frame();
      chk("R6 if1 at frame strobe", if1_stat, 1'b1);
      rx_pad_in = 0; step(2);
      chk("R6 if1 holds without strobe", if1_stat, 1'b1);
      pulse_slot();
      chk("R7 slot ignored for if1", if1_stat, 1'b1);
      net_mode = 1;
      pulse_slot();
      chk("R6 if1 at slot strobe", if1_stat, 1'b0);
   endtask

   task automatic t_bufen();
      syn_mode = 1; bufen_sel = 1; rx_dir = 1; tx_slot_act = 1; #1;
      chk("R8 bufen high", rx_pad_out, 1'b1);
      chk("R8 bufen oe", rx_pad_oe, 1'b1);
      tx_slot_act = 0; #1;
      chk("R8 bufen low", rx_pad_out, 1'b0);
      rx_dir = 0; net_mode = 0; rx_pad_in = 1; step(2);
      chk("R11 idle oe", rx_pad_oe, 1'b0);
      pulse_frame();
      chk("R11 idle pad no capture", if1_stat, 1'b0);
      rx_pad_in = 0; step(2);
   endtask

   task automatic t_gpio();
      rx_gpio_en = 1; rx_gpio_mode = 2'b10; rx_gpio_dout = 1; #1;
      chk("R9 gpio out value", rx_pad_out, 1'b1);
      chk("R9 gpio out oe", rx_pad_oe, 1'b1);
      rx_gpio_mode = 2'b01; rx_pad_in = 1; #1;
      chk("R9 gpio in oe", rx_pad_oe, 1'b0);
      step(2);
      chk("R9 gpio in data", rx_gpio_in, 1'b1);
      syn_mode = 1; bufen_sel = 0; rx_dir = 0; net_mode = 0;
      rx_gpio_mode = 2'b00; step(2);
      chk("R10 disc oe", rx_pad_oe, 1'b0);
      chk("R10 disc gpio in", rx_gpio_in, 1'b0);
      pulse_frame();
      chk("R10 disc if1 unchanged", if1_stat, 1'b0);
      rx_gpio_mode = 2'b11; #1;
      chk("R10 disc mode 11 oe", rx_pad_oe, 1'b0);
      tx_gpio_en = 1; tx_gpio_mode = 2'b00; tx_dir = 0; tx_pad_in = 1; step(3);
      chk("R10 disc tx core fs", tx_fs_core, 1'b0);
      chk("R10 disc tx oe", tx_pad_oe, 1'b0);
   endtask

   initial begin
      t_reset();
      t_async_rx();
      t_tx();
      t_of1();
      t_if1();
      t_bufen();
      t_gpio();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule